// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block is the control state machine that decides which external timing reference a network element's local oscillator follows, and which of two duplicated controller cards drives the system clock. It watches signal-fault flags for a primary and a secondary reference, the lock indication from the oscillator's phase-locked loop, and health flags for controller cards A and B. From these it produces a reference-select code (primary, secondary or holdover), a controller select, a holdover enable and a set of qualified status flags.

Raw faults are filtered before they act. A fault must be present for a programmable hold-off count before a source or card is declared bad. A bad source or card must stay clean for a longer wait-to-restore count before it is trusted again. A reference that passes the signal check is taken as accurate, and no frequency measurement takes part in the choice. A primary that fails to reach lock within a programmable timeout is treated as failed. It is retried after the wait-to-restore period. Both cards receive the same reference selection. Whenever a condition clears, the block returns to the best configuration on its own.

Top module: `refclk_selector`

## Requirements
- R1: `ref_sel` carries 2'b00 for primary, 2'b01 for secondary and 2'b10 for holdover, and never 2'b11. During and right after reset it shows primary, controller A (`card_b_active`=0) and no switch event.
- R2: A fault input must be present for HOLDOFF_CYC consecutive clock edges before the matching qualified flag drops. A shorter burst has no effect on `pri_ok` or `ref_sel`.
- R3: Primary (00) is selected whenever the primary is qualified, `lock_fail` is low and at least one controller card is qualified healthy.
- R4: Once the primary is disqualified, `ref_sel` moves to the secondary one clock edge later, provided the secondary is qualified.
- R5: While primary is selected and `pll_locked` stays low for LOCK_TMO_CYC edges, `lock_fail` rises and selection leaves the primary on the next edge, even though the primary signal is present.
- R6: `lock_fail` clears WTR_CYC edges after it was set, and the primary is then selected again on the next edge if it is qualified.
- R7: When no reference is usable, `ref_sel` is 2'b10 and `holdover_en` is high.
- R8: A disqualified source is requalified after WTR_CYC clean edges, and selection follows one edge later. When both recover together, the primary is picked.
- R9: Card B becomes active (`card_b_active`=1) only while card A is disqualified and card B is qualified. The block returns to card A after card A stays clean for WTR_CYC edges.
- R10: With neither controller card qualified, the block selects holdover.
- R11: Every change of `ref_sel` or `card_b_active` comes with `switch_evt` high in that same cycle, for one cycle when the inputs are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_los | input | 1 | Primary reference signal weak or missing |
| sec_los | input | 1 | Secondary reference signal weak or missing |
| pll_locked | input | 1 | Oscillator loop reports phase lock |
| card_a_ok | input | 1 | Controller card A healthy |
| card_b_ok | input | 1 | Controller card B healthy |
| ref_sel | output | 2 | Selected reference code |
| card_b_active | output | 1 | 1 = card B drives the system clock |
| holdover_en | output | 1 | Oscillators run at their last adjusted rate |
| pri_ok | output | 1 | Primary qualified good |
| sec_ok | output | 1 | Secondary qualified good |
| lock_fail | output | 1 | Primary declared unusable for lack of lock |
| switch_evt | output | 1 | Pulse on any change of reference or card |

## Verification
Each qualifier counter keeps hidden state. A wrong count shows at the ports as `pri_ok`, `sec_ok` or `card_b_active` moving one or more edges early or late, and the bench samples exactly at the predicted edge to catch it. A stuck `lock_fail`, or one that fails to clear, shows as the secondary held after the retry edge or as a primary never left. A wrong priority shows within one edge after settling, in the sweep over all sixteen fault patterns.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    REF_PRI  = 2'b00,
    REF_SEC  = 2'b01,
    REF_HOLD = 2'b10
  } ref_code_t;

  // Priority order: no card means holdover, then primary, then secondary.
  function automatic ref_code_t pick_ref(input logic pri_use,
                                         input logic sec_use,
                                         input logic card_up);
    if (!card_up) return REF_HOLD;
    if (pri_use)  return REF_PRI;
    if (sec_use)  return REF_SEC;
    return REF_HOLD;
  endfunction

  function automatic logic pick_card_b(input logic a_up, input logic b_up);
    return !a_up && b_up;
  endfunction

  function automatic int cnt_width(input int a, input int b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction

endpackage

// File: rtl/refsel_qual.sv
module refsel_qual #(
  parameter int HOLDOFF = 8,
  parameter int WTR     = 64,
  localparam int CW     = refsel_pkg::cnt_width(HOLDOFF, WTR)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic good
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good <= 1'b1;
      cnt  <= '0;
    end else if (good) begin
      if (!fault)                          cnt <= '0;
      else if (cnt == CW'(HOLDOFF - 1)) begin good <= 1'b0; cnt <= '0; end
      else                                 cnt <= cnt + 1'b1;
    end else begin
      if (fault)                           cnt <= '0;
      else if (cnt == CW'(WTR - 1))    begin good <= 1'b1; cnt <= '0; end
      else                                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refsel_lock.sv
module refsel_lock #(
  parameter int TMO   = 16,
  parameter int RETRY = 64,
  localparam int CW   = refsel_pkg::cnt_width(TMO, RETRY)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_pri,
  input  logic locked,
  output logic fail
);
  logic [CW-1:0] tmo_cnt;
  logic [CW-1:0] rty_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail    <= 1'b0;
      tmo_cnt <= '0;
      rty_cnt <= '0;
    end else if (fail) begin
      tmo_cnt <= '0;
      if (rty_cnt == CW'(RETRY - 1)) begin fail <= 1'b0; rty_cnt <= '0; end
      else                                 rty_cnt <= rty_cnt + 1'b1;
    end else begin
      rty_cnt <= '0;
      if (on_pri && !locked) begin
        if (tmo_cnt == CW'(TMO - 1)) begin fail <= 1'b1; tmo_cnt <= '0; end
        else                             tmo_cnt <= tmo_cnt + 1'b1;
      end else begin
        tmo_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector #(
  parameter int HOLDOFF_CYC  = 1000,
  parameter int WTR_CYC      = 50000,
  parameter int LOCK_TMO_CYC = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_los,
  input  logic       sec_los,
  input  logic       pll_locked,
  input  logic       card_a_ok,
  input  logic       card_b_ok,
  output logic [1:0] ref_sel,
  output logic       card_b_active,
  output logic       holdover_en,
  output logic       pri_ok,
  output logic       sec_ok,
  output logic       lock_fail,
  output logic       switch_evt
);
  import refsel_pkg::*;

  localparam int NSRC = 4;  // 0 primary, 1 secondary, 2 card A, 3 card B

  logic [NSRC-1:0] raw_fault;
  logic [NSRC-1:0] src_good;
  logic            card_up;
  ref_code_t       ref_tgt;
  ref_code_t       ref_q;
  logic            card_tgt;
  logic            card_q;
  logic            evt_q;
  logic            on_pri;

  assign raw_fault = {~card_b_ok, ~card_a_ok, sec_los, pri_los};

  for (genvar g = 0; g < NSRC; g++) begin : g_qual
    refsel_qual #(.HOLDOFF(HOLDOFF_CYC), .WTR(WTR_CYC)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .fault (raw_fault[g]),
      .good  (src_good[g])
    );
  end

  assign on_pri = (ref_q == REF_PRI);

  refsel_lock #(.TMO(LOCK_TMO_CYC), .RETRY(WTR_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .on_pri (on_pri),
    .locked (pll_locked),
    .fail   (lock_fail)
  );

  assign card_up  = src_good[2] | src_good[3];
  assign ref_tgt  = pick_ref(src_good[0] && !lock_fail, src_good[1], card_up);
  assign card_tgt = pick_card_b(src_good[2], src_good[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= REF_PRI;
      card_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      ref_q  <= ref_tgt;
      card_q <= card_tgt;
      evt_q  <= (ref_tgt != ref_q) || (card_tgt != card_q);
    end
  end

  assign ref_sel       = ref_q;
  assign card_b_active = card_q;
  assign holdover_en   = (ref_q == REF_HOLD);
  assign pri_ok        = src_good[0];
  assign sec_ok        = src_good[1];
  assign switch_evt    = evt_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pri_los,
  input logic [1:0] ref_sel,
  input logic       card_b_active,
  input logic       holdover_en,
  input logic       pri_ok,
  input logic       sec_ok,
  input logic       lock_fail,
  input logic       switch_evt,
  input logic       card_a_up,
  input logic       card_up
);
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel != 2'b11); // R1
  AST_FAULT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_ok) |-> $past(pri_los)); // R2
  AST_PRI_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == 2'b00 && $past(ref_sel) != 2'b00) |-> $past(pri_ok && !lock_fail)); // R3
  AST_LOCKFAIL_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fail) |=> ref_sel != 2'b00); // R5
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_en) |-> $past(!sec_ok || !card_up)); // R7
  AST_CARD_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_b_active) |-> $past(!card_a_up)); // R9
  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel) || card_b_active != $past(card_b_active)) |-> switch_evt); // R11
endmodule

bind refclk_selector refsel_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pri_los       (pri_los),
  .ref_sel       (ref_sel),
  .card_b_active (card_b_active),
  .holdover_en   (holdover_en),
  .pri_ok        (pri_ok),
  .sec_ok        (sec_ok),
  .lock_fail     (lock_fail),
  .switch_evt    (switch_evt),
  .card_a_up     (src_good[2]),
  .card_up       (card_up)
);

// File: tb/refclk_selector_test.sv
`timescale 1ns/1ps
module refclk_selector_test;
  localparam int HO  = 3;
  localparam int WTR = 6;
  localparam int LT  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pri_los = 1'b0, sec_los = 1'b0, pll_locked = 1'b1;
  logic       card_a_ok = 1'b1, card_b_ok = 1'b1;
  logic [1:0] ref_sel;
  logic       card_b_active, holdover_en, pri_ok, sec_ok, lock_fail, switch_evt;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  refclk_selector #(.HOLDOFF_CYC(HO), .WTR_CYC(WTR), .LOCK_TMO_CYC(LT)) uut (
    .clk(clk), .rst_n(rst_n), .pri_los(pri_los), .sec_los(sec_los),
    .pll_locked(pll_locked), .card_a_ok(card_a_ok), .card_b_ok(card_b_ok),
    .ref_sel(ref_sel), .card_b_active(card_b_active), .holdover_en(holdover_en),
    .pri_ok(pri_ok), .sec_ok(sec_ok), .lock_fail(lock_fail), .switch_evt(switch_evt));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 reset ref", ref_sel, 0);
    check("R1 reset card", card_b_active, 0);
    check("R1 reset evt", switch_evt, 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after reset ref", ref_sel, 0);

    // R2: burst one edge shorter than hold-off
    pri_los = 1'b1; tick(HO - 1); pri_los = 1'b0; tick(WTR + 2);
    check("R2 short burst pri_ok", pri_ok, 1);
    check("R2 short burst ref", ref_sel, 0);

    // R4/R11: primary loss moves to secondary
    pri_los = 1'b1; tick(HO);
    check("R2 pri_ok after holdoff", pri_ok, 0);
    check("R4 ref not yet moved", ref_sel, 0);
    tick(1);
    check("R4 ref secondary", ref_sel, 1);
    check("R11 evt high", switch_evt, 1);
    tick(1);
    check("R11 evt one cycle", switch_evt, 0);

    // R7: secondary lost too
    sec_los = 1'b1; tick(HO + 1);
    check("R7 holdover code", ref_sel, 2);
    check("R7 holdover_en", holdover_en, 1);

    // R8: staged recovery
    sec_los = 1'b0; tick(WTR);
    check("R8 sec requalified", sec_ok, 1);
    check("R8 still holdover", ref_sel, 2);
    tick(1);
    check("R8 back to secondary", ref_sel, 1);
    pri_los = 1'b0; tick(WTR + 1);
    check("R8 back to primary", ref_sel, 0);

    // R8: both recover together from holdover
    pri_los = 1'b1; sec_los = 1'b1; tick(HO + 3);
    check("R7 both lost", ref_sel, 2);
    pri_los = 1'b0; sec_los = 1'b0; tick(WTR);
    check("R8 waiting", ref_sel, 2);
    tick(1);
    check("R8 priority primary", ref_sel, 0);
    tick(2);

    // R5/R6: lock timeout and retry
    pll_locked = 1'b0; tick(LT);
    check("R5 lock_fail", lock_fail, 1);
    check("R5 ref still primary", ref_sel, 0);
    tick(1);
    check("R5 moved to secondary", ref_sel, 1);
    check("R5 primary signal present", pri_ok, 1);
    tick(WTR - 1);
    check("R6 lock_fail cleared", lock_fail, 0);
    check("R6 ref secondary", ref_sel, 1);
    pll_locked = 1'b1; tick(1);
    check("R6 primary retried", ref_sel, 0);
    tick(LT + 2);
    check("R6 stays on primary", ref_sel, 0);

    // R9/R10: controller cards
    card_a_ok = 1'b0; tick(HO + 1);
    check("R9 card B active", card_b_active, 1);
    check("R9 ref unchanged", ref_sel, 0);
    check("R11 evt on card", switch_evt, 1);
    card_b_ok = 1'b0; tick(HO + 1);
    check("R10 no card holdover", ref_sel, 2);
    card_a_ok = 1'b1; card_b_ok = 1'b1; tick(WTR);
    check("R9 card A not yet", ref_sel, 2);
    tick(1);
    check("R9 card A restored", card_b_active, 0);
    check("R3 primary with card A", ref_sel, 0);

    // Sweep all fault patterns to steady state
    for (int m = 0; m < 16; m++) begin
      logic up;
      int   er;
      pri_los = m[0]; sec_los = m[1]; card_a_ok = !m[2]; card_b_ok = !m[3];
      tick(HO + WTR + 4);
      up = !m[2] || !m[3];
      er = !up ? 2 : (!m[0] ? 0 : (!m[1] ? 1 : 2));
      check(!up ? "R10 sweep ref" : (er == 0 ? "R3 sweep ref" : "R7 sweep ref"), ref_sel, er);
      check("R9 sweep card", card_b_active, (m[2] && !m[3]) ? 1 : 0);
      check("R7 sweep holdover_en", holdover_en, (er == 2) ? 1 : 0);
      check("R11 sweep steady evt", switch_evt, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule